// File: doc/BRIEF.md
# Register-Mapped Synchronous Serial Master

This block is a serial master for SPI-style links, controlled through a simple 32-bit register bus. Software sets the clock polarity, the clock phase, the bit order and the frame length. It switches the transmitter, the receiver and master operation on and off with command strobes. It then moves data words through a one-entry transmit buffer and a one-entry receive buffer. A separate divider block provides the bit rate. That block supplies `baud_tick`, one pulse per half bit period, and takes its setting from `clk_div`. Chip selects and pad multiplexing live outside the block. The block exports the pin-enable and location bits for them.

Each frame shifts out the buffered word on `mosi` and shifts `miso` in at the same time. When a frame ends with the receiver enabled, the received word is latched for software. Two interrupt sources, "transmit buffer drained" and "word received", are sticky flags. Software can set them or clear them with separate write-1 aliases. A mask register gates the flags onto `irq`.

Top module: `sser_master`

## Requirements
- R1: After reset every register reads zero except STATUS, which reads 0x40 (buffer free). `sclk`, `irq`, `sclk_oe` and `mosi_oe` are low.
- R2: Readback is masked. CTRL (0x00) keeps bits 0, 8, 9, 10 and 12. FRAME (0x04) keeps [3:0]. CLKDIV (0x14) keeps [20:6], and these bits also appear on `clk_div`. IEN (0x4C) keeps bits 1 and 2. ROUTE (0x54) keeps bits 0, 1, 3 and [10:8]. CMD (0x0C), IFS (0x44) and IFC (0x48) read zero.
- R3: A write to CMD (0x0C) acts per bit. Bit 0 enables the receiver and bit 1 disables it. Bit 2 enables the transmitter and bit 3 disables it. Bit 4 enables master mode. When enable and disable are written together, disable wins. STATUS bit 1 shows the transmitter enable.
- R4: A frame starts only when master mode and the transmitter are both enabled and the transmit buffer is full. Until then `sclk` does not move.
- R5: A frame is FRAME[3:0]+3 bits long. Field values 0 and 14–15 are clamped to 4 and 16 bits.
- R6: `sclk` rests at CTRL bit 8 (polarity). During a frame of n bits it toggles once per `baud_tick`, 2n times in all.
- R7: With CTRL bit 9 (phase) at 0, `miso` is sampled on the 1st, 3rd, … edges. With bit 9 at 1, it is sampled on the 2nd, 4th, … edges. `mosi` is stable at every sample edge. CTRL bit 10 selects MSB first; otherwise LSB first.
- R8: A TXDATA (0x34) write is accepted only while the buffer is empty; a write to a full buffer is dropped. STATUS bit 6 is set while the buffer is empty.
- R9: At the end of each frame with the receiver enabled, the received word is latched right-justified in RXDATAX (0x18) bits [15:0]. It overwrites any unread word and sets STATUS bit 7. A read of RXDATAX clears STATUS bit 7. With the receiver disabled, no word is latched.
- R10: STATUS bit 5 sets when a frame ends and the buffer is empty. It clears on an accepted TXDATA write.
- R11: IF (0x40) bit 1 sets when a frame start drains the buffer. IF bit 2 sets when a word is latched. A 1 written to IFS sets the matching flag and a 1 written to IFC clears it. `irq` is high when any flag is set whose IEN bit is also set.
- R12: ROUTE bit 3 drives `sclk_oe` and bit 1 drives `mosi_oe`. With ROUTE bit 0 clear, `miso` is read as 0. ROUTE[10:8] appears on `pin_loc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_sel | input | 1 | bus access strobe, one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | byte address, word aligned |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, combinational |
| baud_tick | input | 1 | half-bit pulse from the divider |
| clk_div | output | 15 | divider setting |
| sclk | output | 1 | serial clock |
| mosi | output | 1 | serial data out |
| miso | input | 1 | serial data in |
| sclk_oe | output | 1 | clock pin enable |
| mosi_oe | output | 1 | data-out pin enable |
| pin_loc | output | 3 | pin location selector |
| irq | output | 1 | interrupt request |

## Verification
The hardest case to reach is a late word: a second frame that completes while the first received word is still unread. The bus only sees the survivor, so the test must keep from reading between frames. The bench runs two frames back to back without a read and then expects the second pattern. Phase handling is also hard to observe from the bus. A bench-side slave model therefore watches `sclk` edges in every polarity and phase mix, serves `miso` in the configured order, and rebuilds the `mosi` word from the bits held at each sample edge.

// File: rtl/sser_master.sv
module sser_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [6:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        baud_tick,
  output logic [14:0] clk_div,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        sclk_oe,
  output logic        mosi_oe,
  output logic [2:0]  pin_loc,
  output logic        irq
);
  localparam logic [4:0] A_CTRL = 5'h00, A_FRM = 5'h01, A_CMD = 5'h03, A_STAT = 5'h04,
                         A_DIV = 5'h05, A_RXD = 5'h06, A_TXD = 5'h0D, A_FLG = 5'h10,
                         A_FSET = 5'h11, A_FCLR = 5'h12, A_MSK = 5'h13, A_PIN = 5'h15;

  logic       syncm, cpol, cpha, msbf, txlvl;
  logic [3:0] frm;
  logic [1:0] ien, flg;
  logic       rx_pe, tx_pe, ck_pe;
  logic       tx_en, rx_en, mst_en;
  logic [15:0] txbuf, rxbuf, sh;
  logic       txfull, rxv, txc, busy, phase, smp;
  logic [4:0] k;

  wire [4:0] wa = bus_addr[6:2];
  wire       wr = bus_sel & bus_wr;
  wire       rd = bus_sel & ~bus_wr;

  logic [4:0] nbits;
  always_comb begin
    if (frm == 4'd0)      nbits = 5'd4;
    else if (frm > 4'd13) nbits = 5'd16;
    else                  nbits = 5'(frm) + 5'd3;
  end

  wire [5:0]  klast   = {nbits, 1'b0} - 6'd1;
  wire        start   = ~busy & mst_en & tx_en & txfull;
  wire        tick    = busy & baud_tick;
  wire        last    = tick & ({1'b0, k} == klast);
  wire        samp    = tick & (k[0] == cpha);
  wire        shft    = (tick & (k[0] != cpha) & (k != 5'd0)) | (cpha & last);
  wire        miso_i  = miso & rx_pe;
  wire        in_bit  = (cpha & last) ? miso_i : smp;
  wire [15:0] sh_nx   = msbf ? {sh[14:0], in_bit} : {in_bit, sh[15:1]};
  wire [16:0] mask    = (17'd1 << nbits) - 17'd1;
  wire [15:0] rx_word = msbf ? (sh_nx & mask[15:0]) : (sh_nx >> (5'd16 - nbits));
  wire        cap     = last & rx_en;
  wire        txd_acc = wr & (wa == A_TXD) & ~txfull;
  wire        set_wr  = wr & (wa == A_FSET);
  wire        clr_wr  = wr & (wa == A_FCLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {syncm, cpol, cpha, msbf, txlvl} <= '0;
      frm <= '0; clk_div <= '0; ien <= '0; flg <= '0;
      {rx_pe, tx_pe, ck_pe} <= '0; pin_loc <= '0;
      {tx_en, rx_en, mst_en} <= '0;
      txbuf <= '0; rxbuf <= '0; sh <= '0;
      {txfull, rxv, txc, busy, phase, smp} <= '0;
      k <= '0;
    end else begin
      if (wr) begin
        case (wa)
          A_CTRL: {txlvl, msbf, cpha, cpol, syncm} <=
                  {bus_wdata[12], bus_wdata[10], bus_wdata[9], bus_wdata[8], bus_wdata[0]};
          A_FRM:  frm <= bus_wdata[3:0];
          A_DIV:  clk_div <= bus_wdata[20:6];
          A_MSK:  ien <= bus_wdata[2:1];
          A_PIN:  {pin_loc, ck_pe, tx_pe, rx_pe} <=
                  {bus_wdata[10:8], bus_wdata[3], bus_wdata[1], bus_wdata[0]};
          A_CMD: begin
            rx_en  <= (rx_en | bus_wdata[0]) & ~bus_wdata[1];
            tx_en  <= (tx_en | bus_wdata[2]) & ~bus_wdata[3];
            mst_en <= mst_en | bus_wdata[4];
          end
          default: ;
        endcase
      end

      flg <= (flg & ~({2{clr_wr}} & bus_wdata[2:1])) | ({2{set_wr}} & bus_wdata[2:1])
             | {cap, start};

      if (txd_acc) txbuf <= bus_wdata[15:0];
      if (start)        txfull <= 1'b0;
      else if (txd_acc) txfull <= 1'b1;

      if (txd_acc)                 txc <= 1'b0;
      else if (last && !txfull)    txc <= 1'b1;

      if (cap) begin
        rxbuf <= rx_word;
        rxv   <= 1'b1;
      end else if (rd && wa == A_RXD) begin
        rxv <= 1'b0;
      end

      if (start) begin
        busy  <= 1'b1;
        k     <= '0;
        phase <= 1'b0;
        sh    <= msbf ? (txbuf << (5'd16 - nbits)) : txbuf;
      end else if (tick) begin
        phase <= ~phase;
        k     <= k + 5'd1;
        if (samp) smp <= miso_i;
        if (shft) sh <= sh_nx;
        if (last) busy <= 1'b0;
      end
    end
  end

  assign sclk    = cpol ^ phase;
  assign mosi    = msbf ? sh[15] : sh[0];
  assign sclk_oe = ck_pe;
  assign mosi_oe = tx_pe;
  assign irq     = |(flg & ien);

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (wa)
        A_CTRL: bus_rdata = {19'd0, txlvl, 1'b0, msbf, cpha, cpol, 7'd0, syncm};
        A_FRM:  bus_rdata = {28'd0, frm};
        A_STAT: bus_rdata = {24'd0, rxv, ~txfull, txc, 3'd0, tx_en, 1'b0};
        A_DIV:  bus_rdata = {11'd0, clk_div, 6'd0};
        A_RXD:  bus_rdata = {16'd0, rxbuf};
        A_FLG:  bus_rdata = {29'd0, flg, 1'b0};
        A_MSK:  bus_rdata = {29'd0, ien, 1'b0};
        A_PIN:  bus_rdata = {21'd0, pin_loc, 4'd0, ck_pe, 1'b0, tx_pe, rx_pe};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sser_master_chk.sv
module sser_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [6:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        busy,
  input logic        sclk,
  input logic        cpol,
  input logic        txfull,
  input logic        txc,
  input logic        rxv,
  input logic        cap,
  input logic        start,
  input logic        mst_en,
  input logic        tx_en,
  input logic [15:0] txbuf,
  input logic [1:0]  flg
);
  wire txd_wr = bus_sel & bus_wr & (bus_addr[6:2] == 5'h0D);
  wire ifc_rx = bus_sel & bus_wr & (bus_addr[6:2] == 5'h12) & bus_wdata[2];

  a_r4_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(mst_en && tx_en));

  a_r6_sclk_rest: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cpol);

  a_r8_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
    txfull && txd_wr && !start |=> $stable(txbuf));

  a_r9_latch: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> rxv);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    txc |-> !txfull && !busy);

  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ifc_rx && !cap |=> !flg[1]);
endmodule

bind sser_master sser_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy), .sclk(sclk),
  .cpol(cpol), .txfull(txfull), .txc(txc), .rxv(rxv), .cap(cap),
  .start(start), .mst_en(mst_en), .tx_en(tx_en), .txbuf(txbuf), .flg(flg)
);

// File: tb/sser_master_tb.sv
`timescale 1ns/1ps
module sser_master_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        baud_tick = 1'b0;
  logic [14:0] clk_div;
  logic        sclk, mosi, miso = 1'b0, sclk_oe, mosi_oe, irq;
  logic [2:0]  pin_loc;

  int total = 0, bad = 0;

  sser_master u_dut (.*);

  always #2 clk = ~clk;

  typedef struct packed {
    logic [3:0] frm; logic cpol; logic cpha; logic msbf; logic [4:0] n;
    logic [15:0] tx; logic [15:0] mi; logic [15:0] exp_mosi; logic [15:0] exp_rx;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{4'd5,  1'b0, 1'b0, 1'b1, 5'd8,  16'h00A5, 16'h003C, 16'h00A5, 16'h003C},
    '{4'd1,  1'b1, 1'b1, 1'b0, 5'd4,  16'hFFF9, 16'h0006, 16'h0009, 16'h0006},
    '{4'd13, 1'b0, 1'b1, 1'b1, 5'd16, 16'h1234, 16'hBEEF, 16'h1234, 16'hBEEF},
    '{4'd9,  1'b1, 1'b0, 1'b0, 5'd12, 16'h0ABC, 16'hF123, 16'h0ABC, 16'h0123},
    '{4'd0,  1'b0, 1'b0, 1'b1, 5'd4,  16'h00D7, 16'h0005, 16'h0007, 16'h0005},
    '{4'd15, 1'b1, 1'b1, 1'b1, 5'd16, 16'h8001, 16'h7FFE, 16'h8001, 16'h7FFE}
  };

  // slave model state
  int          s_n = 8, s_j = 0, s_tog = 0;
  logic        s_msbf = 1'b1, s_cpol = 1'b0, s_cpha = 1'b0;
  logic [15:0] s_mi = '0, s_cap = '0;
  logic        p_sclk = 1'b0, p_mosi = 1'b0;

  function automatic int bidx(int j);
    return s_msbf ? (s_n - 1 - j) : j;
  endfunction

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc++;
      baud_tick = (tc % 4 == 0);
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        summary();
      end
      if (sclk !== p_sclk) begin
        s_tog++;
        if (((p_sclk == s_cpol) != s_cpha) && s_j < s_n) begin
          s_cap[bidx(s_j)] = p_mosi;
          s_j++;
        end
      end
      p_sclk = sclk;
      p_mosi = mosi;
      miso = (s_j < s_n) ? s_mi[bidx(s_j)] : 1'b0;
    end
  end

  task automatic arm(int n, logic ms, logic cp, logic ph, logic [15:0] mi);
    @(negedge clk); #1;
    s_n = n; s_msbf = ms; s_cpol = cp; s_cpha = ph; s_mi = mi;
    s_j = 0; s_tog = 0; s_cap = '0; p_sclk = sclk; p_mosi = mosi;
    miso = mi[ms ? n - 1 : 0];
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_done();
    logic [31:0] st;
    for (int i = 0; i < 400; i++) begin
      rd(7'h10, st);
      if (st[5]) return;
    end
    chk("R10 frame end", st[5], 1);
  endtask

  task automatic frame(logic [3:0] f, logic cp, logic ph, logic ms, int n,
                       logic [15:0] tx, logic [15:0] mi, logic do_rd,
                       output logic [15:0] rxw);
    logic [31:0] d;
    wr(7'h00, 32'h1 | (32'(cp) << 8) | (32'(ph) << 9) | (32'(ms) << 10));
    wr(7'h04, 32'(f));
    arm(n, ms, cp, ph, mi);
    wr(7'h34, 32'(tx));
    wait_done();
    rxw = '0;
    if (do_rd) begin
      rd(7'h18, d);
      rxw = d[15:0];
    end
  endtask

  initial begin
    logic [31:0] d;
    logic [15:0] rw;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sclk", sclk, 0);
    chk("R1 irq", irq, 0);
    chk("R1 oe", {sclk_oe, mosi_oe}, 0);
    rst_n = 1'b1;
    rd(7'h10, d); chk("R1 status", d, 32'h40);
    rd(7'h00, d); chk("R1 ctrl", d, 0);

    // R2 readback masks
    wr(7'h00, 32'hFFFF_FFFF); rd(7'h00, d); chk("R2 ctrl", d, 32'h1701);
    wr(7'h04, 32'hFFFF_FFFF); rd(7'h04, d); chk("R2 frame", d, 32'hF);
    wr(7'h14, 32'hFFFF_FFFF); rd(7'h14, d); chk("R2 clkdiv", d, 32'h1F_FFC0);
    chk("R2 clk_div", clk_div, 15'h7FFF);
    wr(7'h4C, 32'hFFFF_FFFF); rd(7'h4C, d); chk("R2 ien", d, 32'h6);
    wr(7'h4C, 32'h0);
    rd(7'h0C, d); chk("R2 cmd", d, 0);
    rd(7'h44, d); chk("R2 ifs", d, 0);
    wr(7'h54, 32'hFFFF_FFFF); rd(7'h54, d); chk("R2 route", d, 32'h70B);
    chk("R12 pins", {pin_loc, sclk_oe, mosi_oe}, {3'd7, 2'b11});
    wr(7'h00, 32'h401);
    wr(7'h04, 32'h5);

    // R4 / R8: no master enable yet
    wr(7'h0C, 32'h05);
    rd(7'h10, d); chk("R3 tx enabled", d[1], 1);
    arm(8, 1'b1, 1'b0, 1'b0, 16'h0);
    wr(7'h34, 32'h55);
    repeat (60) @(negedge clk);
    chk("R4 no clock", s_tog, 0);
    rd(7'h10, d); chk("R8 buffer full", d[6], 0);
    wr(7'h34, 32'hAA);
    wr(7'h0C, 32'h10);
    wait_done();
    chk("R8 dropped write", s_cap, 16'h55);
    rd(7'h18, d);

    // table of transfers: R5 R6 R7 R9
    foreach (VEC[i]) begin
      frame(VEC[i].frm, VEC[i].cpol, VEC[i].cpha, VEC[i].msbf, int'(VEC[i].n),
            VEC[i].tx, VEC[i].mi, 1'b1, rw);
      chk("R7 mosi word", s_cap, VEC[i].exp_mosi);
      chk("R9 rx word", rw, VEC[i].exp_rx);
      chk("R5 R6 toggles", s_tog, 2 * int'(VEC[i].n));
      chk("R6 rest level", sclk, VEC[i].cpol);
    end

    // R9 overwrite and consume
    frame(4'd5, 0, 0, 1, 8, 16'h11, 16'h5A, 1'b0, rw);
    frame(4'd5, 0, 0, 1, 8, 16'h22, 16'hC3, 1'b0, rw);
    rd(7'h10, d); chk("R9 valid", d[7], 1);
    rd(7'h18, d); chk("R9 overwrite", d, 32'hC3);
    rd(7'h10, d); chk("R9 consumed", d[7], 0);

    // R3 receiver disable, disable wins
    wr(7'h0C, 32'h02);
    frame(4'd5, 0, 0, 1, 8, 16'h33, 16'h99, 1'b0, rw);
    rd(7'h10, d); chk("R3 rx off", d[7], 0);
    wr(7'h0C, 32'h01);
    wr(7'h0C, 32'h0C);
    rd(7'h10, d); chk("R3 disable wins", d[1], 0);
    wr(7'h0C, 32'h04);
    rd(7'h10, d); chk("R3 re-enable", d[1], 1);

    // R11 flags
    wr(7'h48, 32'h6);
    frame(4'd5, 0, 0, 1, 8, 16'h44, 16'h12, 1'b1, rw);
    rd(7'h40, d); chk("R11 hw flags", d, 32'h6);
    chk("R11 masked", irq, 0);
    wr(7'h4C, 32'h4); chk("R11 irq on", irq, 1);
    wr(7'h48, 32'h4); rd(7'h40, d); chk("R11 ifc", d, 32'h2);
    chk("R11 irq off", irq, 0);
    wr(7'h44, 32'h4); rd(7'h40, d); chk("R11 ifs", d, 32'h6);
    chk("R11 irq set", irq, 1);
    wr(7'h4C, 32'h0); chk("R11 unmask", irq, 0);

    // R12 miso ignored without receive pin enable
    wr(7'h54, 32'h0A);
    frame(4'd5, 0, 0, 1, 8, 16'h66, 16'hFF, 1'b1, rw);
    chk("R12 miso gated", rw, 0);
    wr(7'h54, 32'h01);
    chk("R12 oe off", {sclk_oe, mosi_oe}, 0);

    // R10 complete flag clears on accepted write
    rd(7'h10, d); chk("R10 set", d[5], 1);
    wr(7'h0C, 32'h08);
    wr(7'h34, 32'h77);
    rd(7'h10, d); chk("R10 cleared", d[6:5], 2'b00);

    summary();
  end
endmodule